// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block takes 16-bit command words from a three-wire serial link made of an active-low frame select, a serial clock and a data line. All three pins are oversampled in the system clock domain. Once select is seen low, the block shifts in one data bit on each falling edge of the serial clock, most significant bit first. When the sixteenth bit arrives, the block delivers the word on a parallel output together with a one-cycle valid pulse. It does this at once, without waiting for select to return high.

A frame is discarded if select goes high before all sixteen bits have arrived. After a complete word the receiver ignores any further clock and data activity until select has been raised and lowered again. An enable flag is high only while a frame is actually collecting bits. It stands for the powered state of the serial input buffers and can gate them in the surrounding logic.

Top module: `cmd_serial_rx`

## Requirements
- R1: While the synchronized select is high, serial clock and data activity has no effect: no valid pulse is issued, the word output is unchanged and the enable flag stays low.
- R2: Bits are taken on falling edges of the serial clock while select is low. The first bit taken becomes bit 15 of the word and the sixteenth becomes bit 0.
- R3: Each completed frame produces exactly one valid pulse, one system clock wide. The pulse is seen SYNC_STAGES+1 rising system clock edges after the sixteenth falling serial clock edge at the pin (three edges at the default).
- R4: The word and its valid pulse are delivered while select is still low. No select rise is needed.
- R5: If select rises after fewer than 16 falling edges (0 to 15), no valid pulse is issued and the word output keeps its previous value.
- R6: After the sixteenth bit, further serial clock edges with select still low are ignored until select goes high and then low again. The internal bit count never exceeds 16.
- R7: The enable flag rises SYNC_STAGES+1 rising edges after the select falling edge at the pin. It falls on the same edge that raises the valid pulse, and it also falls when a frame is aborted.
- R8: The word output holds its value between valid pulses.
- R9: When rst_n is low at a rising clock edge, the valid pulse, enable flag and word output go to zero, and the receiver returns to idle with select treated as high.
- R10: Every select falling edge restarts the bit count from zero. Bits left over from an aborted frame never appear in a later word.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are oversampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n_i | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdi_i | input | 1 | Serial data, MSB first |
| word_o | output | WORD_W (16) | Last complete command word |
| word_valid_o | output | 1 | One-cycle pulse when word_o takes a new word |
| rx_en_o | output | 1 | High while a frame is collecting bits |

## Verification
The bench sweeps aborted frames of every length from 0 to 15 bits. A receiver with an off-by-one bit count would deliver a word on the fifteenth bit, and one that ignored the abort would overwrite the word. The bench sends extra clocks after a complete word with select still low. A receiver without lockout would shift those bits in and pulse valid a second time. It also follows a 15-bit abort with a full frame, to expose a count that is not cleared on select fall. The bench checks the exact cycle of the valid pulse and of the enable flag edges against the synchronizer depth, so any extra or missing register shows up as a timing mismatch.

// File: rtl/cmd_rx_pkg.sv
// Shared types for the serial command receiver.
package cmd_rx_pkg;
    // Bundle of the three raw serial pins, MSB first: select, clock, data.
    typedef struct packed {
        logic sel_n;
        logic sclk;
        logic sdi;
    } pins_t;

    // Idle pin level used when resetting synchronizers: select inactive.
    localparam pins_t PINS_IDLE = '{sel_n: 1'b1, sclk: 1'b0, sdi: 1'b0};
endpackage

// File: rtl/cmd_rx_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes the pins are slow relative to clk (each level held for
// several clk cycles); every bit gets the same STAGES of delay.
module cmd_rx_sync #(
    parameter int STAGES = 2,
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the pin bundle through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cmd_rx_edges.sv
// Edge detector for synchronized select and serial clock.
// Assumes inputs already synchronized to clk. Outputs are
// combinational strobes, one clk cycle wide.
module cmd_rx_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n_s,
    input  logic sclk_s,
    output logic sel_fall,
    output logic sclk_fall
);
    logic sel_q;
    logic sclk_q;

    // Remember last cycle's levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            sel_q  <= sel_n_s;
            sclk_q <= sclk_s;
        end
    end

    assign sel_fall  = sel_q & ~sel_n_s;
    assign sclk_fall = sclk_q & ~sclk_s;
endmodule

// File: rtl/cmd_rx_frame.sv
// Frame controller: bit counter, shift register, word capture,
// abort on early select rise and lockout after a full word.
// Assumes strobes from cmd_rx_edges and data synchronized with
// the same delay as the serial clock.
module cmd_rx_frame #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_s,
    input  logic              sel_fall,
    input  logic              sclk_fall,
    input  logic              sdi_s,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              en_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic              active;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] shreg_next;

    // Next shift-register value with the new bit appended as LSB.
    assign shreg_next = {shreg[WORD_W-2:0], sdi_s};

    // Frame sequencing: start, abort, shift, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            active  <= 1'b0;
            shreg   <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (sel_fall) begin
                cnt    <= '0;
                active <= 1'b1;
            end else if (sel_n_s) begin
                active <= 1'b0;
            end else if (active && sclk_fall) begin
                shreg <= shreg_next;
                cnt   <= cnt + 1'b1;
                if (cnt == LAST_IDX) begin
                    active  <= 1'b0;
                    word_o  <= shreg_next;
                    valid_o <= 1'b1;
                end
            end
        end
    end

    assign en_o = active;

    // R3: valid is never two cycles long.
    assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: word changes only together with a valid pulse.
    assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(word_o));

    // R5: a high select in one cycle forbids a valid pulse on the next.
    assert_abort_no_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> !valid_o);

    // R6: count saturates at the word length.
    assert_cnt_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(WORD_W));

    // R6: while not collecting and no new frame, clock edges move nothing.
    assert_lockout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !sel_fall) |=> ($stable(cnt) && $stable(shreg)));

    // R7: enable is already low when the word is presented.
    assert_en_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !en_o);
endmodule

// File: rtl/cmd_serial_rx.sv
// Framed serial command receiver top. Synchronizes the three
// serial pins, detects edges and assembles WORD_W-bit words.
// Assumes serial pin levels last several clk cycles.
module cmd_serial_rx #(
    parameter int WORD_W = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid_o,
    output logic              rx_en_o
);
    import cmd_rx_pkg::*;

    localparam int PIN_W = $bits(pins_t);

    pins_t raw_pins;
    pins_t sync_pins;
    logic  sel_fall;
    logic  sclk_fall;

    assign raw_pins = '{sel_n: sel_n_i, sclk: sclk_i, sdi: sdi_i};

    cmd_rx_sync #(
        .STAGES (SYNC_STAGES),
        .W      (PIN_W),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_pins),
        .q_o  (sync_pins)
    );

    cmd_rx_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n_s  (sync_pins.sel_n),
        .sclk_s   (sync_pins.sclk),
        .sel_fall (sel_fall),
        .sclk_fall(sclk_fall)
    );

    cmd_rx_frame #(
        .WORD_W(WORD_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n_s  (sync_pins.sel_n),
        .sel_fall (sel_fall),
        .sclk_fall(sclk_fall),
        .sdi_s    (sync_pins.sdi),
        .word_o   (word_o),
        .valid_o  (word_valid_o),
        .en_o     (rx_en_o)
    );
endmodule

// File: tb/sim_cmd_serial_rx.sv
// Bench for cmd_serial_rx: sweeps words and abort lengths,
// checks timing of valid and enable against the sync depth.
module sim_cmd_serial_rx;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdi = 1'b0;
    logic [W-1:0] word;
    logic         valid;
    logic         rx_en;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    int long_pulses = 0;
    logic prev_valid = 1'b0;

    always #10 clk = ~clk;

    cmd_serial_rx #(.WORD_W(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk),
        .sdi_i(sdi), .word_o(word), .word_valid_o(valid), .rx_en_o(rx_en)
    );

    // Count valid pulses and pulses longer than one cycle.
    always @(posedge clk) begin
        if (rst_n) begin
            if (valid) pulses++;
            if (valid && prev_valid) long_pulses++;
        end
        prev_valid <= valid;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b; sclk = 1'b1; wt(4);
        sclk = 1'b0; wt(4);
    endtask

    // Frame: nbits data bits MSB first, then extra clocks, then select high.
    task automatic frame(input logic [W-1:0] w, input int nbits, input int extra);
        sel_n = 1'b0; wt(6);
        for (int i = 0; i < nbits; i++) send_bit(w[W-1-i]);
        for (int i = 0; i < extra; i++) send_bit(i[0]);
        wt(6);
        sel_n = 1'b1; wt(8);
    endtask

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", checks, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] exp_w;
        int p0;
        wt(3);
        rst_n = 1'b1;
        wt(1);
        // R9 reset state
        chk(word == 0 && !valid && !rx_en, "R9 reset state", {word, valid, rx_en}, 0);

        // R1: clocks with select high do nothing
        for (int i = 0; i < 20; i++) send_bit(i[1]);
        chk(pulses == 0 && word == 0 && !rx_en, "R1 idle clocks ignored", pulses, 0);

        // R7, R3, R4: exact timing of enable and valid
        exp_w = 16'hC35A;
        sel_n = 1'b0;
        repeat (2) @(posedge clk); @(negedge clk);
        chk(!rx_en, "R7 enable not yet", rx_en, 0);
        @(posedge clk); @(negedge clk);
        chk(rx_en, "R7 enable rises", rx_en, 1);
        wt(3);
        for (int i = 0; i < W - 1; i++) send_bit(exp_w[W-1-i]);
        chk(rx_en, "R7 enable held during frame", rx_en, 1);
        sdi = exp_w[0]; sclk = 1'b1; wt(4);
        sclk = 1'b0;
        repeat (2) @(posedge clk); @(negedge clk);
        chk(!valid, "R3 valid not early", valid, 0);
        @(posedge clk); @(negedge clk);
        chk(valid && word == exp_w, "R3 R4 valid with select low", word, exp_w);
        chk(!rx_en, "R7 enable falls with valid", rx_en, 0);
        @(negedge clk);
        chk(!valid, "R3 single cycle", valid, 0);
        // R6: extra clocks after full word with select low
        p0 = pulses;
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        chk(pulses == p0 && word == exp_w && !rx_en, "R6 lockout", word, exp_w);
        wt(6); sel_n = 1'b1; wt(8);
        chk(word == exp_w, "R8 word held after select rise", word, exp_w);

        // R2: walking ones and arithmetic patterns
        for (int k = 0; k < W; k++) begin
            p0 = pulses;
            exp_w = 16'(1 << k);
            frame(exp_w, W, 0);
            chk(pulses == p0 + 1 && word == exp_w, "R2 walking one", word, exp_w);
        end
        for (int k = 0; k < 8; k++) begin
            p0 = pulses;
            exp_w = 16'(k * 16'h1357) ^ 16'(k << 9) ^ 16'hFFFF * 16'(k[0]);
            frame(exp_w, W, 3);
            chk(pulses == p0 + 1 && word == exp_w, "R2 R6 pattern with trailing clocks", word, exp_w);
        end

        // R5: aborts of every short length
        for (int n = 0; n < W; n++) begin
            p0 = pulses;
            exp_w = word;
            frame(~exp_w, n, 0);
            chk(pulses == p0 && word == exp_w && !rx_en, "R5 abort", word, exp_w);
        end

        // R10: full frame after a 15-bit abort
        frame(16'hFFFF, W - 1, 0);
        p0 = pulses;
        frame(16'h0001, W, 0);
        chk(pulses == p0 + 1 && word == 16'h0001, "R10 count restarts", word, 16'h0001);

        chk(long_pulses == 0, "R3 no long pulses", long_pulses, 0);

        // R9: reset clears word
        @(negedge clk); rst_n = 1'b0; wt(2); rst_n = 1'b1; wt(1);
        chk(word == 0 && !valid && !rx_en, "R9 reset clears", word, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule